// File: doc/BRIEF.md
# Operand-Gated Eight-Operation ALU

A combinational 8-bit arithmetic and logic unit. It takes two operands, a carry input and a 3-bit operation code, and returns a result word and a carry output. Four arithmetic operations share one carry-lookahead adder: add, subtract, increment and decrement. Four bitwise operations run in a separate logic unit: NAND, NOR, XOR and NOT.

A decoder turns the operation code into one-hot unit enables. Each enable gates the operands of its own unit, so every idle unit sees all-zero inputs and does not switch. The adder is enabled for any arithmetic code. Its second operand is conditioned by three stages in order. First, B is gated so that it passes only for add and subtract. Next, an OR stage forces a unit value for increment and decrement. Last, an XOR stage inverts the operand for subtract and decrement. A per-bit multiplexer bank then routes the active unit's word to the result port. The decoded enables are also driven out, so that surrounding logic can see which unit is active.

There is no clock and no state. The outputs follow the inputs within the same evaluation.

Top module: `alu_gated`

## Requirements
- R1: With op_i = 3'b000 (add), {carry_o, result_o} equals a_i + b_i + carry_i, taken as a 9-bit sum.
- R2: With op_i = 3'b001 (subtract), result_o equals a_i - b_i modulo 256. carry_o is 1 exactly when a_i >= b_i, taken as unsigned values. carry_i has no effect.
- R3: With op_i = 3'b010 (increment), result_o equals a_i + 1 modulo 256, and carry_o is 1 only when a_i = 8'hFF. b_i and carry_i have no effect.
- R4: With op_i = 3'b011 (decrement), result_o equals a_i - 1 modulo 256, and carry_o is 0 only when a_i = 8'h00. b_i and carry_i have no effect.
- R5: With op_i = 3'b100, result_o equals the bitwise NAND of a_i and b_i.
- R6: With op_i = 3'b101, result_o equals the bitwise NOR of a_i and b_i.
- R7: With op_i = 3'b110, result_o equals the bitwise XOR of a_i and b_i.
- R8: With op_i = 3'b111, result_o equals the bitwise inverse of a_i, and b_i has no effect.
- R9: Whenever op_i[2] is 1 (any logic operation), carry_o is 0, whatever carry_i is.
- R10: unit_en_o is one-hot, and its bit at index op_i is the one that is set. The adder operands are zero whenever op_i[2] is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand |
| carry_i | input | 1 | Carry input, used only by add |
| op_i | input | 3 | Operation code |
| result_o | output | 8 | Result of the selected operation |
| carry_o | output | 1 | Adder carry output, 0 for logic operations |
| unit_en_o | output | 8 | One-hot unit enables decoded from op_i |

## Verification
Directed vectors cover the cases where the carry chain and the operand conditioning show up at the ports:
- all-ones plus all-ones with carry in, which runs the full carry chain;
- 0 - 1 and equal-operand subtraction, which are the two sides of the borrow;
- incrementing 8'hFF and decrementing 8'h00, which are the wrap points where a wrong forced unit value or a missing inversion gives a different carry.

Seeded random vectors then sweep all eight codes with random B and random carry-in. On the increment, decrement, subtract and logic codes, this shows whether B or carry_i leaks through a path that should be gated. Comparing unit_en_o for every code separates a decoder fault from a multiplexer fault.

// File: rtl/alu_gated_pkg.sv
package alu_gated_pkg;
  localparam int unsigned OP_W  = 3;
  localparam int unsigned N_OPS = 1 << OP_W;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_INC  = 3'd2,
    OP_DEC  = 3'd3,
    OP_NAND = 3'd4,
    OP_NOR  = 3'd5,
    OP_XOR  = 3'd6,
    OP_NOT  = 3'd7
  } op_e;
endpackage

// File: rtl/alu_op_decoder.sv
module alu_op_decoder #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned N = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [N-1:0]     en_o
);
  for (genvar k = 0; k < N; k++) begin : g_dec
    assign en_o[k] = (sel_i == SEL_W'(k));
  end
endmodule

// File: rtl/alu_cla_adder.sv
module alu_cla_adder #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [WIDTH-1:0] gen, prop;
  logic [WIDTH:0]   carry;

  // one-bit slices: generate/propagate and sum
  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    assign gen[i]   = a_i[i] & b_i[i];
    assign prop[i]  = a_i[i] ^ b_i[i];
    assign sum_o[i] = prop[i] ^ carry[i];
  end

  // flat lookahead: each carry formed directly from g/p and cin
  always_comb begin
    carry[0] = cin_i;
    for (int i = 1; i <= WIDTH; i++) begin
      logic term;
      logic c;
      term = cin_i;
      for (int j = 0; j < i; j++) term = term & prop[j];
      c = term;
      for (int j = 0; j < i; j++) begin
        term = gen[j];
        for (int k = j + 1; k < i; k++) term = term & prop[k];
        c = c | term;
      end
      carry[i] = c;
    end
  end

  assign cout_o = carry[WIDTH];
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0]      a_i,
  input  logic [WIDTH-1:0]      b_i,
  input  logic [3:0]            en_i,   // nand, nor, xor, not
  output logic [3:0][WIDTH-1:0] res_o
);
  logic [3:0][WIDTH-1:0] a_g, b_g;

  // per-function operand isolation
  for (genvar k = 0; k < 4; k++) begin : g_iso
    assign a_g[k] = a_i & {WIDTH{en_i[k]}};
    assign b_g[k] = b_i & {WIDTH{en_i[k]}};
  end

  assign res_o[0] = ~(a_g[0] & b_g[0]);
  assign res_o[1] = ~(a_g[1] | b_g[1]);
  assign res_o[2] = a_g[2] ^ b_g[2];
  assign res_o[3] = ~a_g[3];
endmodule

// File: rtl/alu_result_mux.sv
module alu_result_mux #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned SEL_W = 3,
  localparam int unsigned N = 1 << SEL_W
) (
  input  logic [SEL_W-1:0]        sel_i,
  input  logic [N-1:0][WIDTH-1:0] data_i,
  output logic [WIDTH-1:0]        data_o
);
  // one N:1 mux per result bit
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [N-1:0] col;
    for (genvar k = 0; k < N; k++) begin : g_col
      assign col[k] = data_i[k][b];
    end
    assign data_o[b] = col[sel_i];
  end
endmodule

// File: rtl/alu_gated.sv
module alu_gated
  import alu_gated_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic [N_OPS-1:0] unit_en_o
);
  logic [N_OPS-1:0] en;
  logic             arith_en, b_pass, b_one, b_inv, add_cin, add_cout;
  logic [WIDTH-1:0] add_a, add_b, add_sum;
  logic [3:0][WIDTH-1:0]     logic_res;
  logic [N_OPS-1:0][WIDTH-1:0] unit_res;

  alu_op_decoder #(.SEL_W(OP_W)) u_dec (
    .sel_i (op_i),
    .en_o  (en)
  );

  assign arith_en = en[OP_ADD] | en[OP_SUB] | en[OP_INC] | en[OP_DEC];
  assign b_pass   = en[OP_ADD] | en[OP_SUB];
  assign b_one    = en[OP_INC] | en[OP_DEC];
  assign b_inv    = en[OP_SUB] | en[OP_DEC];

  // adder operand conditioning: gate, OR-force unit value, XOR invert
  assign add_a   = a_i & {WIDTH{arith_en}};
  assign add_b   = ((b_i & {WIDTH{b_pass}}) | {{(WIDTH-1){1'b0}}, b_one})
                   ^ {WIDTH{b_inv}};
  assign add_cin = (en[OP_ADD] & carry_i) | b_inv;

  alu_cla_adder #(.WIDTH(WIDTH)) u_add (
    .a_i    (add_a),
    .b_i    (add_b),
    .cin_i  (add_cin),
    .sum_o  (add_sum),
    .cout_o (add_cout)
  );

  alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .en_i  (en[OP_NOT:OP_NAND]),
    .res_o (logic_res)
  );

  for (genvar k = 0; k < N_OPS; k++) begin : g_route
    if (k < 4) begin : g_arith
      assign unit_res[k] = add_sum;
    end else begin : g_logic
      assign unit_res[k] = logic_res[k-4];
    end
  end

  alu_result_mux #(.WIDTH(WIDTH), .SEL_W(OP_W)) u_mux (
    .sel_i  (op_i),
    .data_i (unit_res),
    .data_o (result_o)
  );

  assign carry_o   = add_cout & arith_en;
  assign unit_en_o = en;
endmodule

// File: rtl/alu_gated_chk.sv
module alu_gated_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             carry_i,
  input logic [2:0]       op_i,
  input logic [WIDTH-1:0] result_o,
  input logic             carry_o,
  input logic [7:0]       unit_en_o,
  input logic [WIDTH-1:0] add_a,
  input logic [WIDTH-1:0] add_b
);
  logic known;
  assign known = !$isunknown({a_i, b_i, carry_i, op_i});

  always_comb begin
    if (known) begin
      // R10
      en_onehot_chk: assert ($onehot(unit_en_o) && unit_en_o[op_i]);
      // R10
      adder_iso_chk: assert (!op_i[2] || (add_a == '0 && add_b == '0));
      // R9
      logic_carry_chk: assert (!op_i[2] || !carry_o);
      // R1
      add_sum_chk: assert (op_i != 3'd0 ||
        {carry_o, result_o} == ({1'b0, a_i} + {1'b0, b_i} + (WIDTH+1)'(carry_i)));
      // R8
      not_res_chk: assert (op_i != 3'd7 || result_o == ~a_i);
    end
  end
endmodule

bind alu_gated alu_gated_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i       (a_i),
  .b_i       (b_i),
  .carry_i   (carry_i),
  .op_i      (op_i),
  .result_o  (result_o),
  .carry_o   (carry_o),
  .unit_en_o (unit_en_o),
  .add_a     (add_a),
  .add_b     (add_b)
);

// File: tb/alu_gated_test.sv
module alu_gated_test;
  logic       clk = 1'b0;
  logic [7:0] a, b, res;
  logic       cin, cout;
  logic [2:0] op;
  logic [7:0] en;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  alu_gated uut (
    .a_i(a), .b_i(b), .carry_i(cin), .op_i(op),
    .result_o(res), .carry_o(cout), .unit_en_o(en)
  );

  function automatic logic [8:0] model(logic [2:0] o, logic [7:0] x, logic [7:0] y, logic c);
    case (o)
      3'd0: return {1'b0, x} + {1'b0, y} + {8'd0, c};
      3'd1: return {(x >= y), 8'(x - y)};
      3'd2: return {(x == 8'hFF), 8'(x + 8'd1)};
      3'd3: return {(x != 8'h00), 8'(x - 8'd1)};
      3'd4: return {1'b0, ~(x & y)};
      3'd5: return {1'b0, ~(x | y)};
      3'd6: return {1'b0, x ^ y};
      default: return {1'b0, ~x};
    endcase
  endfunction

  function automatic string req_of(logic [2:0] o);
    case (o)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: op=%0d a=%h b=%h cin=%b actual=%h expected=%h",
               req, op, a, b, cin, act, exp);
    end
  endtask

  task automatic apply(logic [2:0] o, logic [7:0] x, logic [7:0] y, logic c);
    logic [8:0] exp;
    @(negedge clk);
    op = o; a = x; b = y; cin = c;
    #1;
    exp = model(o, x, y, c);
    check(req_of(o), {1'b0, res}, {1'b0, exp[7:0]});
    if (o[2]) check("R9", {8'd0, cout}, 9'd0);
    else      check(req_of(o), {8'd0, cout}, {8'd0, exp[8]});
    check("R10", {1'b0, en}, {1'b0, 8'(8'd1 << o)});
  endtask

  initial begin
    op = 3'd0; a = 8'd0; b = 8'd0; cin = 1'b0;
    #2;
    check("R1", {cout, res}, 9'd0);   // quiescent start
    apply(3'd0, 8'h01, 8'h19, 1'b1);  // R1 -> 1B
    apply(3'd0, 8'hFF, 8'hFF, 1'b1);  // R1 full chain
    apply(3'd1, 8'h08, 8'h01, 1'b0);  // R2 -> 07, carry 1
    apply(3'd1, 8'h00, 8'h01, 1'b1);  // R2 borrow, cin ignored
    apply(3'd1, 8'h5A, 8'h5A, 1'b0);  // R2 equal operands
    apply(3'd2, 8'hFF, 8'h33, 1'b1);  // R3 wrap
    apply(3'd3, 8'h00, 8'hC4, 1'b1);  // R4 wrap
    apply(3'd3, 8'h80, 8'h00, 1'b0);  // R4
    apply(3'd4, 8'hF0, 8'hAA, 1'b1);  // R5
    apply(3'd5, 8'h18, 8'h06, 1'b1);  // R6
    apply(3'd6, 8'hA5, 8'h0F, 1'b0);  // R7
    apply(3'd7, 8'h01, 8'hFF, 1'b1);  // R8 -> FE
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3000; i++)
      apply(3'($urandom), 8'($urandom), 8'($urandom), 1'($urandom));
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #150000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule